// File: doc/BRIEF.md
# Byte Series Sequencer with Serial Transmitter

This block sends a short, fixed series of bytes over an asynchronous serial line each time it is started. A control state machine offers the bytes one at a time to a bit-serial transmitter. For each byte it raises a one-cycle send strobe, and the transmitter answers with a registered busy flag. That flag goes high only one clock after the strobe is taken. If the sequencer looked at busy on that same cycle, it would see a stale low and could issue the next byte too early. To prevent this, the machine passes through a settle state after every strobe and only checks busy again after that.

A single-cycle `go_i` pulse starts a series. While a series is in progress, further pulses are ignored. After the last byte the machine goes back to idle and waits for the next pulse. The first byte is 0x35 and the second is 0xAA. If `SEQ_LEN` is set larger than 2, byte index k ≥ 2 is 0xAA XOR k. The transmitter sends 8N1 frames with a fixed clocks-per-bit divider.

Top module: `byte_seq_uart_top`

## Requirements
- R1: While reset is held and right after it is released, `txd_o` is 1, `send_stb_o` is 0, `tx_busy_o` is 0, `seq_active_o` is 0 and `send_byte_o` holds 0x35.
- R2: A one-cycle `go_i` pulse in idle makes `send_stb_o` rise two clock edges after the cycle in which `go_i` was high. The serial line then carries byte 0x35 followed by byte 0xAA, each exactly once.
- R3: `send_stb_o` is never high for two cycles in a row, and it is only high while `tx_busy_o` is low.
- R4: `tx_busy_o` is high in the cycle after every strobe, and it never rises without a strobe in the previous cycle.
- R5: Within a series, consecutive strobes are exactly 10·CLKS_PER_BIT + 2 cycles apart. Busy is seen high between them, so no byte is issued twice or dropped.
- R6: `send_byte_o` holds the same value in the strobe cycle as in the cycle before it. That value is the series byte for the strobe's position.
- R7: Each frame is 10·CLKS_PER_BIT cycles long and starts at the rise of busy. It has a 0 start bit, then 8 data bits with the least significant bit first, then a 1 stop bit, and each bit lasts CLKS_PER_BIT clocks. The line is 1 whenever busy is low.
- R8: `go_i` pulses while `seq_active_o` is high have no effect: no extra strobe and no extra byte appears on the line.
- R9: After the last byte's settle cycle, `seq_active_o` falls. A new `go_i` pulse then repeats the whole series from the first byte, after any idle gap including zero cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | 1 | Start pulse for one series |
| txd_o | output | 1 | Serial line, idle high |
| send_stb_o | output | 1 | One-cycle strobe from sequencer to transmitter |
| send_byte_o | output | 8 | Byte register offered to the transmitter |
| tx_busy_o | output | 1 | Registered transmitter busy flag |
| seq_active_o | output | 1 | High while a series is in progress |

## Verification
A sequencer that skipped its settle state would let the second strobe appear within a few cycles of the first. This shows at once as a strobe while busy is high, or as a strobe spacing shorter than one frame. A wrong byte register shows on the strobe cycle itself, and a wrong transmitter shift shows when the frame is decoded, one frame time later. A state machine that fails to return to idle, or that restarts on a stray pulse, shows up as a missing or extra byte once the series has drained. The sweep covers every combination of restart gap 0 to 4 and ignored pulse count 0 to 3.

// File: rtl/byte_seq_pkg.sv
// Package: shared state type and the byte series for the sequencer.
// Assumes series positions fit in 8 bits.
package byte_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SEND   = 2'd1,
        SQ_SETTLE = 2'd2,
        SQ_LOAD   = 2'd3
    } seq_state_t;

    localparam logic [7:0] FIRST_BYTE  = 8'b0011_0101;
    localparam logic [7:0] SECOND_BYTE = 8'b1010_1010;
    localparam int unsigned FRAME_BITS = 10;

    // Byte for a given series position; positions beyond the second are derived.
    function automatic logic [7:0] series_byte(input logic [7:0] idx);
        logic [7:0] b;
        case (idx)
            8'd0:    b = FIRST_BYTE;
            8'd1:    b = SECOND_BYTE;
            default: b = SECOND_BYTE ^ idx;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// Offers SEQ_LEN bytes, one at a time, to a transmitter whose busy flag is
// registered. After every strobe it spends one settle cycle so the busy flag
// has caught up before it is sampled again. The data register is loaded
// before the strobe cycle. Assumes SEQ_LEN between 1 and 256.
module seq_fsm #(
    parameter int SEQ_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic       tx_busy_i,
    output logic       stb_o,
    output logic [7:0] data_o,
    output logic       active_o
);
    import byte_seq_pkg::*;

    localparam int IDX_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

    seq_state_t       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       data_q;
    logic             stb_q;

    // Sequencing: idle preloads byte 0, send waits for not-busy, settle
    // absorbs the busy lag, load fetches the next byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            data_q  <= FIRST_BYTE;
            stb_q   <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    stb_q  <= 1'b0;
                    idx_q  <= '0;
                    data_q <= series_byte(8'd0);
                    if (go_i) state_q <= SQ_SEND;
                end
                SQ_SEND: begin
                    if (!tx_busy_i) begin
                        stb_q   <= 1'b1;
                        state_q <= SQ_SETTLE;
                    end
                end
                SQ_SETTLE: begin
                    stb_q <= 1'b0;
                    if (idx_q == LAST_IDX) begin
                        state_q <= SQ_IDLE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= SQ_LOAD;
                    end
                end
                SQ_LOAD: begin
                    data_q  <= series_byte(8'(idx_q));
                    state_q <= SQ_SEND;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign stb_o    = stb_q;
    assign data_o   = data_q;
    assign active_o = (state_q != SQ_IDLE);

endmodule

// File: rtl/baud_tick.sv
// Module: baud_tick
// Emits a one-cycle tick every CLKS_PER_BIT cycles while run is high,
// restarting its count whenever run is low. Assumes CLKS_PER_BIT >= 1.
module baud_tick #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CLKS_PER_BIT - 1);

    generate
        if (CLKS_PER_BIT == 1) begin : g_every_cycle
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign tick_o = run_i;
        end else begin : g_divider
            logic [CNT_W-1:0] cnt_q;
            // Divider counter: counts 0..CNT_TOP while running.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i)      cnt_q <= '0;
                else if (cnt_q == CNT_TOP) cnt_q <= '0;
                else                       cnt_q <= cnt_q + 1'b1;
            end
            assign tick_o = run_i && (cnt_q == CNT_TOP);
        end
    endgenerate

endmodule

// File: rtl/uart_tx_frame.sv
// Module: uart_tx_frame
// 8N1 transmitter. A strobe taken while idle latches the byte and raises
// busy on the next edge (registered). The frame is shifted out least
// significant bit first; busy falls at the end of the stop bit.
// Strobes while busy are ignored.
module uart_tx_frame #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_i,
    input  logic [7:0] data_i,
    output logic       busy_o,
    output logic       txd_o
);
    import byte_seq_pkg::*;

    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    logic                  busy_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic [BIT_W-1:0]      bit_q;
    logic                  tick;

    baud_tick #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (busy_q),
        .tick_o(tick)
    );

    // Frame engine: latch on accepted strobe, shift on each bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            shreg_q <= '1;
            bit_q   <= '0;
        end else if (!busy_q) begin
            if (stb_i) begin
                busy_q  <= 1'b1;
                shreg_q <= {1'b1, data_i, 1'b0};
                bit_q   <= '0;
            end
        end else if (tick) begin
            if (bit_q == LAST_BIT) begin
                busy_q  <= 1'b0;
                shreg_q <= '1;
            end else begin
                shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
                bit_q   <= bit_q + 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign txd_o  = shreg_q[0];

endmodule

// File: rtl/byte_seq_uart_top.sv
// Module: byte_seq_uart_top
// Joins the byte sequencer to the serial transmitter and exposes the
// handshake for observation. Assumes one clock domain.
module byte_seq_uart_top #(
    parameter int CLKS_PER_BIT = 16,
    parameter int SEQ_LEN      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    output logic       txd_o,
    output logic       send_stb_o,
    output logic [7:0] send_byte_o,
    output logic       tx_busy_o,
    output logic       seq_active_o
);
    logic       stb;
    logic [7:0] data;
    logic       busy;

    seq_fsm #(.SEQ_LEN(SEQ_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go_i),
        .tx_busy_i(busy),
        .stb_o    (stb),
        .data_o   (data),
        .active_o (seq_active_o)
    );

    uart_tx_frame #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (stb),
        .data_i(data),
        .busy_o(busy),
        .txd_o (txd_o)
    );

    assign send_stb_o  = stb;
    assign send_byte_o = data;
    assign tx_busy_o   = busy;

endmodule

// File: rtl/byte_seq_uart_chk.sv
// Module: byte_seq_uart_chk
// Protocol checks on the sequencer/transmitter handshake and frame length.
module byte_seq_uart_chk #(
    parameter int CLKS_PER_BIT = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       txd_o,
    input logic       send_stb_o,
    input logic [7:0] send_byte_o,
    input logic       tx_busy_o
);
    localparam int FRAME_CLKS = 10 * CLKS_PER_BIT;

    logic [31:0] busy_run_q;

    // Busy run-length counter for the frame length check.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_busy_o) busy_run_q <= '0;
        else                      busy_run_q <= busy_run_q + 1'b1;
    end

    p_stb_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        send_stb_o |-> !tx_busy_o);
    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        send_stb_o |=> !send_stb_o);
    p_busy_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        send_stb_o |=> tx_busy_o);
    p_busy_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy_o) |-> $past(send_stb_o));
    p_byte_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        send_stb_o |-> $stable(send_byte_o));
    p_line_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy_o |-> txd_o);
    p_start_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy_o) |-> !txd_o);
    p_frame_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy_o) |-> (busy_run_q == 32'(FRAME_CLKS)));

endmodule

bind byte_seq_uart_top byte_seq_uart_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txd_o      (txd_o),
    .send_stb_o (send_stb_o),
    .send_byte_o(send_byte_o),
    .tx_busy_o  (tx_busy_o)
);

// File: tb/tb_byte_seq_uart_top.sv
// Bench: sweeps restart gaps and ignored go pulses, decodes the serial line.
module tb_byte_seq_uart_top;
    localparam int CPB   = 4;
    localparam int SEQ   = 2;
    localparam int FRAME = 10 * CPB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic       txd, stb, busy, active;
    logic [7:0] sbyte;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int cyc    = 0;

    logic [7:0] dec_mem [0:255];
    int dec_n = 0;
    int stb_n = 0;
    int last_stb_cyc = 0;
    bit stb_pend = 1'b0;
    int busy_len = 0;
    int expected_total = 0;

    byte_seq_uart_top #(.CLKS_PER_BIT(CPB), .SEQ_LEN(SEQ)) dut (
        .clk(clk), .rst_n(rst_n), .go_i(go), .txd_o(txd),
        .send_stb_o(stb), .send_byte_o(sbyte), .tx_busy_o(busy),
        .seq_active_o(active)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] exp_byte(input int k);
        return ((k % SEQ) == 0) ? 8'h35 : 8'hAA;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Strobe, spacing, byte and busy-length monitor.
    always @(negedge clk) begin
        if (rst_n) begin
            if (stb_pend) begin
                chk(busy === 1'b1, "R4", "busy after strobe", busy, 1);
                chk(stb === 1'b0, "R3", "strobe width", stb, 0);
                stb_pend = 1'b0;
            end
            if (stb) begin
                chk(busy === 1'b0, "R3", "busy at strobe", busy, 0);
                chk(sbyte == exp_byte(stb_n), "R6", "byte at strobe", sbyte, exp_byte(stb_n));
                if ((stb_n % SEQ) != 0)
                    chk(cyc - last_stb_cyc == FRAME + 2, "R5", "strobe spacing",
                        cyc - last_stb_cyc, FRAME + 2);
                last_stb_cyc = cyc;
                stb_n++;
                stb_pend = 1'b1;
            end
            if (busy) busy_len++;
            else if (busy_len != 0) begin
                chk(busy_len == FRAME, "R7", "busy length", busy_len, FRAME);
                busy_len = 0;
            end
        end
    end

    // Serial decoder: mid-bit sampling of 8N1 frames.
    initial begin
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                repeat (CPB / 2) @(negedge clk);
                chk(txd === 1'b0, "R7", "start bit", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (CPB) @(negedge clk);
                    b[i] = txd;
                end
                repeat (CPB) @(negedge clk);
                chk(txd === 1'b1, "R7", "stop bit", txd, 1);
                if (dec_n < 256) dec_mem[dec_n] = b;
                dec_n++;
            end
        end
    end

    // One series: go pulse, optional ignored pulses, wait for drain.
    task automatic run_series(input int pulses);
        int first_n;
        first_n = stb_n;
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        chk(active === 1'b1, "R2", "active after go", active, 1);
        chk(stb === 1'b0, "R2", "no strobe yet", stb, 0);
        @(negedge clk);
        chk(stb === 1'b1, "R2", "strobe latency", stb, 1);
        for (int p = 0; p < pulses; p++) begin
            repeat (9) @(negedge clk);
            if (active) begin
                go = 1'b1;
                @(negedge clk) go = 1'b0;
            end
        end
        for (int w = 0; w < 2000; w++) begin
            @(negedge clk);
            if (!active && !busy) break;
        end
        expected_total += SEQ;
        chk(stb_n - first_n == SEQ, "R8", "strobes per series", stb_n - first_n, SEQ);
        chk(dec_n == expected_total, "R2", "bytes decoded", dec_n, expected_total);
        chk(active === 1'b0, "R9", "back to idle", active, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(txd === 1'b1, "R1", "txd in reset", txd, 1);
        chk(stb === 1'b0 && busy === 1'b0, "R1", "strobe/busy in reset", stb | busy, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(sbyte == 8'h35, "R1", "byte after reset", sbyte, 8'h35);
        chk(active === 1'b0 && txd === 1'b1, "R1", "idle after reset", active, 0);
        for (int gap = 0; gap <= 4; gap++) begin
            for (int pulses = 0; pulses <= 3; pulses++) begin
                run_series(pulses);
                repeat (gap) @(negedge clk);
            end
        end
        repeat (5) @(negedge clk);
        chk(dec_n == expected_total, "R9", "total bytes", dec_n, expected_total);
        for (int k = 0; k < dec_n && k < 256; k++)
            if (dec_mem[k] != exp_byte(k))
                chk(1'b0, "R2", "decoded byte order", dec_mem[k], exp_byte(k));
        chk(stb_n == expected_total, "R8", "total strobes", stb_n, expected_total);
        finish_run();
    end

endmodule